// File: doc/BRIEF.md
# Four-Way Set-Associative Read Cache

This block is a read-only, unified, on-chip cache for a 32-bit processor with byte addresses. It holds 8 KB of data in 128 sets of four ways, and each line carries sixteen bytes as four 32-bit words. The processor presents an address with a one-cycle read strobe. On a hit, the requested word comes back with a one-cycle ready pulse in the next cycle. On a miss, the block reads the whole line from the memory side as a four-beat burst and installs it into a victim way. It then answers the processor.

Each set keeps a three-bit pseudo-LRU tree. Victim choice prefers invalid ways, and the tree is consulted only when all four ways of the set are valid. Only one request is handled at a time. A strobe that arrives while the block is busy is dropped.

The controller has four states:
- `ST_IDLE` waits for a strobe. IDLE->LOOKUP happens when a strobe is seen, and the address is latched at that point.
- `ST_LOOKUP` compares the tags. LOOKUP->IDLE happens on a hit, with the answer given during LOOKUP. LOOKUP->FILL happens on a miss, and the victim way is latched at that point.
- `ST_FILL` holds the burst request and accepts beats. FILL->RESP happens when the fourth beat is accepted, and the tag and valid bit are written on that same edge.
- `ST_RESP` returns the filled word. RESP->IDLE follows unconditionally.

Top module: `rdc_top`

## Requirements
- R1: The address splits into tag bits 31:11, set index bits 10:4 and line offset bits 3:0. Bits 3:2 select the word within the line, and bits 1:0 do not affect the result.
- R2: After reset, every line is invalid and every tree bit is 0. The first access to any address after reset misses, and `cpu_ready` and `mem_req` are low while in reset.
- R3: A hit raises `cpu_ready` for one cycle, in the cycle right after the strobe, with the correct word. A hit makes no memory request.
- R4: A miss raises `mem_req` with `mem_addr` equal to the request address with bits 3:0 cleared. Both stay steady until four beats have been accepted. Beats are qualified by `mem_valid`, arrive as word 0 to word 3, and may have gaps between them.
- R5: On a miss, `cpu_ready` rises in the cycle right after the edge that accepts the fourth beat. In that same cycle `mem_req` drops, and `cpu_data` carries the requested word of the new line. With a gap-free burst, `cpu_ready` arrives 6 cycles after the strobe.
- R6: The victim is the lowest-numbered invalid way of the set, if there is one.
- R7: With all ways valid, the victim follows the tree. The bits are B0 (bit 0), B1 (bit 1) and B2 (bit 2). If B0 is 0, the victim comes from ways {0,1} and B1 picks the way; otherwise it comes from {2,3} and B2 picks the way. A hit or a fill to way w sets the bits on w's path to point away from w.
- R8: A strobe while a request is in progress is ignored. It produces no extra response and no extra burst.
- R9: `cpu_ready` never stays high for two cycles in a row and is never high while `mem_req` is high.
- R10: Sets are independent. The same tag with a different set index misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_rd | input | 1 | Read strobe |
| cpu_data | output | 32 | Returned word |
| cpu_ready | output | 1 | One-cycle answer strobe |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_data | input | 32 | Burst beat data |
| mem_valid | input | 1 | Beat valid strobe |

## Verification
The assertions watch the following on every cycle:
- The single-cycle nature of `cpu_ready` and its exclusion with `mem_req`.
- The alignment and steadiness of the burst address.
- That a ready pulse can only follow a strobe or the end of a burst.
- That the end of a burst always coincides with a ready pulse.

The following can only be shown by the bench's scenarios, because each depends on which lines are resident:
- Victim selection, both the invalid-first rule and the tree order.
- The returned data.
- Set independence.
- The dropping of strobes while busy.
- The clearing of lines by reset.

// File: rtl/rdc_pkg.sv
package rdc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_RESP
    } rdc_state_t;
endpackage

// File: rtl/rdc_plru.sv
// Victim choice and tree update for one four-way set.
module rdc_plru (
    input  logic [2:0] tree_i,
    input  logic [3:0] valid_i,
    input  logic [1:0] acc_way_i,
    output logic [1:0] victim_o,
    output logic [2:0] tree_next_o
);
    always_comb begin
        if (!valid_i[0])      victim_o = 2'd0;
        else if (!valid_i[1]) victim_o = 2'd1;
        else if (!valid_i[2]) victim_o = 2'd2;
        else if (!valid_i[3]) victim_o = 2'd3;
        else if (!tree_i[0])  victim_o = {1'b0, tree_i[1]};
        else                  victim_o = {1'b1, tree_i[2]};
    end

    always_comb begin
        tree_next_o = tree_i;
        if (!acc_way_i[1]) begin
            tree_next_o[0] = 1'b1;
            tree_next_o[1] = ~acc_way_i[0];
        end else begin
            tree_next_o[0] = 1'b0;
            tree_next_o[2] = ~acc_way_i[0];
        end
    end
endmodule

// File: rtl/rdc_way.sv
// Storage of one way: valid bits, tags, data words.
module rdc_way #(
    parameter int SETS   = 128,
    parameter int TAG_W  = 21,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(SETS),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [WSEL_W-1:0] rd_word_i,
    input  logic              data_we_i,
    input  logic [WSEL_W-1:0] wr_word_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              tag_we_i,
    input  logic [TAG_W-1:0]  tag_i,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] data_o
);
    logic [SETS-1:0]   valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [DATA_W-1:0] data_mem [SETS][WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        valid_q <= '0;
        else if (tag_we_i) valid_q[idx_i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (tag_we_i)  tag_mem[idx_i] <= tag_i;
        if (data_we_i) data_mem[idx_i][wr_word_i] <= wr_data_i;
    end

    assign valid_o = valid_q[idx_i];
    assign tag_o   = tag_mem[idx_i];
    assign data_o  = data_mem[idx_i][rd_word_i];
endmodule

// File: rtl/rdc_ctrl.sv
// Request sequencer: lookup, burst fill, response.
module rdc_ctrl
    import rdc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORDS  = 4,
    parameter int OFF_W  = 4,
    localparam int WSEL_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    input  logic              hit_i,
    input  logic [1:0]        victim_i,
    input  logic              mem_valid_i,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [1:0]        fill_way_o,
    output logic [WSEL_W-1:0] beat_o,
    output logic              beat_we_o,
    output logic              last_beat_o,
    output logic              hit_upd_o,
    output logic              cpu_ready_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o
);
    localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

    rdc_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cpu_rd_i) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit_i ? ST_IDLE : ST_FILL;
            ST_FILL:   if (mem_valid_i && beat_o == LAST_BEAT) state_d = ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            req_addr_o <= '0;
            fill_way_o <= '0;
            beat_o     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_rd_i) req_addr_o <= cpu_addr_i;
            if (state_q == ST_LOOKUP) begin
                fill_way_o <= victim_i;
                beat_o     <= '0;
            end else if (state_q == ST_FILL && mem_valid_i) begin
                beat_o <= beat_o + 1'b1;
            end
        end
    end

    always_comb begin
        beat_we_o   = (state_q == ST_FILL) && mem_valid_i;
        last_beat_o = beat_we_o && (beat_o == LAST_BEAT);
        hit_upd_o   = (state_q == ST_LOOKUP) && hit_i;
        cpu_ready_o = hit_upd_o || (state_q == ST_RESP);
        mem_req_o   = (state_q == ST_FILL);
        mem_addr_o  = {req_addr_o[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end
endmodule

// File: rtl/rdc_top.sv
module rdc_top #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SETS   = 128,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_data,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_valid
);
    localparam int WAYS   = 4;
    localparam int IDX_W  = $clog2(SETS);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int OFF_W  = WSEL_W + $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

    logic [ADDR_W-1:0] req_addr;
    logic [1:0]        fill_way, victim, hit_way, upd_way;
    logic [WSEL_W-1:0] beat;
    logic              beat_we, last_beat, hit_upd, hit;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_word;
    logic [WAYS-1:0]   way_valid, way_hit;
    logic [TAG_W-1:0]  way_tag  [WAYS];
    logic [DATA_W-1:0] way_data [WAYS];
    logic [2:0]        tree_q [SETS];
    logic [2:0]        tree_next;

    assign idx      = req_addr[OFF_W +: IDX_W];
    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_word = req_addr[OFF_W-1 -: WSEL_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        rdc_way #(.SETS(SETS), .TAG_W(TAG_W), .WORDS(WORDS), .DATA_W(DATA_W)) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .idx_i     (idx),
            .rd_word_i (req_word),
            .data_we_i (beat_we && fill_way == 2'(w)),
            .wr_word_i (beat),
            .wr_data_i (mem_data),
            .tag_we_i  (last_beat && fill_way == 2'(w)),
            .tag_i     (req_tag),
            .valid_o   (way_valid[w]),
            .tag_o     (way_tag[w]),
            .data_o    (way_data[w])
        );
        assign way_hit[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) if (way_hit[w]) hit_way = 2'(w);
    end

    assign hit      = |way_hit;
    assign cpu_data = way_data[hit_way];
    assign upd_way  = hit_upd ? hit_way : fill_way;

    rdc_plru u_plru (
        .tree_i      (tree_q[idx]),
        .valid_i     (way_valid),
        .acc_way_i   (upd_way),
        .victim_o    (victim),
        .tree_next_o (tree_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (hit_upd || last_beat) begin
            tree_q[idx] <= tree_next;
        end
    end

    rdc_ctrl #(.ADDR_W(ADDR_W), .WORDS(WORDS), .OFF_W(OFF_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd_i    (cpu_rd),
        .cpu_addr_i  (cpu_addr),
        .hit_i       (hit),
        .victim_i    (victim),
        .mem_valid_i (mem_valid),
        .req_addr_o  (req_addr),
        .fill_way_o  (fill_way),
        .beat_o      (beat),
        .beat_we_o   (beat_we),
        .last_beat_o (last_beat),
        .hit_upd_o   (hit_upd),
        .cpu_ready_o (cpu_ready),
        .mem_req_o   (mem_req),
        .mem_addr_o  (mem_addr)
    );
endmodule

// File: rtl/rdc_checker.sv
module rdc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_rd,
    input logic        cpu_ready,
    input logic        mem_req,
    input logic [31:0] mem_addr
);
    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_ready_not_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_ready && mem_req));

    assert_line_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[3:0] == 4'd0));

    assert_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req)) |-> $stable(mem_addr));

    assert_fill_answers_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_req) |-> cpu_ready);

    assert_ready_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_ready) |-> ($past(cpu_rd) || $past(mem_req)));
endmodule

bind rdc_top rdc_checker u_rdc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_rd    (cpu_rd),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr)
);

// File: tb/tb_rdc_top.sv
module tb_rdc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic [31:0] cpu_data;
    logic        cpu_ready;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic [31:0] mem_data = '0;
    logic        mem_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    int bursts = 0;
    int beat_n = 0;
    int cyc = 0;
    bit gap_mode = 1'b0;
    bit gap_done = 1'b0;

    always #4 clk = ~clk;

    rdc_top dut (.*);

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h0001_0003) ^ 32'hC0DE_5A00;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: beats in ascending order, optional stall before beat 2
    always @(negedge clk) begin
        if (mem_req && beat_n < 4) begin
            if (beat_n == 0) begin
                bursts++;
                check(mem_addr[3:0] == 4'd0, "R4 aligned burst address", mem_addr, {mem_addr[31:4], 4'd0});
            end
            if (gap_mode && beat_n == 2 && !gap_done) begin
                gap_done  = 1'b1;
                mem_valid = 1'b0;
            end else begin
                mem_valid = 1'b1;
                mem_data  = mem_word(mem_addr + 32'(beat_n * 4));
                beat_n++;
            end
        end else begin
            mem_valid = 1'b0;
            if (!mem_req) begin
                beat_n   = 0;
                gap_done = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic do_read(input logic [31:0] a, input bit exp_hit, input int exp_lat, input string req);
        int b0;
        int lat;
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        b0       = bursts;
        @(negedge clk);
        cpu_rd = 1'b0;
        lat    = 1;
        while (!cpu_ready && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        check(cpu_ready, {req, " ready seen"}, 32'(cpu_ready), 32'd1);
        check(cpu_data == mem_word(a), {req, " data"}, cpu_data, mem_word(a));
        check((bursts == b0) == exp_hit, {req, " hit/miss"}, 32'(bursts - b0), exp_hit ? 32'd0 : 32'd1);
        if (exp_lat > 0)
            check(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
    endtask

    // {expect_hit, address}; set 5, tags 1..5 (A..E)
    localparam logic [32:0] VEC [12] = '{
        {1'b0, 32'h0000_0850},  // A miss -> way0 (R2, R6)
        {1'b1, 32'h0000_0858},  // A word2 hit (R1, R3)
        {1'b0, 32'h0000_1054},  // B miss -> way1 (R6)
        {1'b0, 32'h0000_1858},  // C miss -> way2 (R6)
        {1'b0, 32'h0000_205C},  // D miss -> way3 (R6)
        {1'b1, 32'h0000_0853},  // A hit, low bits ignored (R1)
        {1'b0, 32'h0000_2850},  // E miss, tree picks way2, evicts C (R7)
        {1'b1, 32'h0000_0854},  // A hit
        {1'b1, 32'h0000_1050},  // B hit
        {1'b1, 32'h0000_2050},  // D hit
        {1'b0, 32'h0000_1850},  // C miss, tree picks way0, evicts A (R7)
        {1'b0, 32'h0000_0850}   // A miss (R7)
    };

    initial begin
        repeat (3) @(negedge clk);
        check(!cpu_ready && !mem_req, "R2 reset outputs", {30'd0, cpu_ready, mem_req}, 32'd0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            do_read(VEC[i][31:0], VEC[i][32], VEC[i][32] ? 1 : 6, $sformatf("R7 vec%0d", i));
        end

        // R10: same tag, different set
        do_read(32'h0000_3000, 1'b0, 6, "R10 set0");
        do_read(32'h0000_3010, 1'b0, 6, "R10 set1");
        do_read(32'h0000_3004, 1'b1, 1, "R10 set0 rehit");

        // R4: burst with a stall before beat 2
        gap_mode = 1'b1;
        do_read(32'h0000_5078, 1'b0, 7, "R4 gapped burst");
        gap_mode = 1'b0;

        // R8: strobe during a fill is ignored
        begin
            int b0;
            bit extra;
            @(negedge clk);
            cpu_addr = 32'h0000_1230;
            cpu_rd   = 1'b1;
            @(negedge clk);
            cpu_rd = 1'b0;
            @(negedge clk);
            cpu_addr = 32'h0000_4440;
            cpu_rd   = 1'b1;
            @(negedge clk);
            cpu_rd   = 1'b0;
            cpu_addr = 32'h0000_1230;
            while (!cpu_ready) @(negedge clk);
            check(cpu_data == mem_word(32'h0000_1230), "R8 original answered", cpu_data, mem_word(32'h0000_1230));
            b0    = bursts;
            extra = 1'b0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (cpu_ready || mem_req) extra = 1'b1;
            end
            check(!extra && bursts == b0, "R8 no extra activity", 32'(extra), 32'd0);
        end
        do_read(32'h0000_4440, 1'b0, 6, "R8 dropped addr misses");

        // R2: reset clears lines
        do_read(32'h0000_1054, 1'b1, 1, "R2 pre-reset hit");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!cpu_ready && !mem_req, "R2 outputs in reset", {30'd0, cpu_ready, mem_req}, 32'd0);
        rst_n = 1'b1;
        do_read(32'h0000_1054, 1'b0, 6, "R2 post-reset miss");

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule